// File: doc/BRIEF.md
# Adaptive Threshold-Pruned Trellis Decoder

This block recovers information bits from a hard-decision stream produced by a rate-1/2 convolutional encoder with a memory of two bits, giving a four-state trellis. One received code pair is accepted per step. For every state the block adds a Hamming branch metric to the cost of each of its two predecessors and keeps the cheaper one. It then thins out the trellis. A state survives only if its cost is below the best surviving cost of the previous step plus a threshold. The number of survivors must also stay under a fixed cap. If too many states pass, the threshold is walked down in steps of two until the count fits, so the metrics never have to be sorted.

Each state carries a 16-bit register-exchange history. The decoded bit is the oldest history bit of the cheapest survivor, and it is emitted once 16 pairs have been accepted. A matching encoder module sits beside the decoder for stimulus generation. Both stream edges use valid/ready. A pair is taken on a clock edge where `in_valid` and `in_ready` are both high. A decoded bit is held, with `out_valid` high and `out_bit` stable, until a clock edge where `out_ready` is high. While a held bit is not taken, `in_ready` is low, so no pair is lost or overwritten.

Top module: `avit_decoder`

## Requirements
- R1: The encoder keeps a two-bit state {newest, older}, which starts at 00 after reset. For an input bit u it emits sym[1] = u^newest^older and sym[0] = u^older, then moves to {u, newest}.
- R2: After a synchronous reset, `out_valid` is low and `in_ready` is high. Only state index 0 (state 00) is alive, with cost 0. The next pair decodes from that start.
- R3: On an error-free stream, every decoded bit equals the corresponding encoder input bit. The branch metric is the number of differing bits between `in_sym` and the branch label. On equal cost, the predecessor with the older bit 0 wins.
- R4: The first `out_valid` follows the edge that accepts the 16th pair and carries the first message bit. Each later accepted pair yields the next bit in order.
- R5: With `thr_cfg` at 6 or 8, a single flipped received bit is corrected, provided flips are at least 20 pairs apart.
- R6: A candidate state is retained only if its new cost is strictly below dm + T. Here dm is the least cost among the previous survivors, and T starts each step at `thr_cfg`.
- R7: While NMAX or more candidates pass, T drops by 2, floored at 0, and the test is repeated. The retained set therefore never reaches NMAX states (default NMAX 4).
- R8: If no candidate passes, only the cheapest candidate is retained, with the lowest index winning a tie. The decoder never loses every survivor, so `thr_cfg` = 0 still decodes an error-free stream.
- R9: Retained costs are stored minus dm in 8-bit saturating form and never reach the saturation value. Decoding stays correct over runs with more than 255 accumulated errors.
- R10: While `out_valid` is high and `out_ready` is low, `out_bit` and `out_valid` hold, `in_ready` is low, and trellis state does not change. The pending pair is accepted once `out_ready` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| thr_cfg | input | 4 | Starting pruning threshold T for each step |
| in_valid | input | 1 | Received pair is present |
| in_ready | output | 1 | Decoder can take a pair this cycle |
| in_sym | input | 2 | Received pair, bit 1 is the first code bit |
| out_valid | output | 1 | Decoded bit is present |
| out_ready | input | 1 | Consumer takes the decoded bit |
| out_bit | output | 1 | Decoded information bit |

## Verification
The bench aims at the threshold extremes. With T of 1 only the exact-cost path passes; a design using less-or-equal there would keep extra paths. With T of 0 nothing passes, and a design without the keep-cheapest fallback would lose every survivor and emit garbage. A large T makes all four states pass, so the cap forces the ladder down; a missing ladder would overrun the cap. A long erroneous run exposes missing renormalisation, which would saturate the costs and then break ties wrongly. A stalled output checks that a design does not drop or overwrite a pending pair or decoded bit.

// File: rtl/avd_pkg.sv
package avd_pkg;
  localparam int NS = 4;

  function automatic logic [1:0] branch_label(input logic [1:0] st, input logic u);
    return {u ^ st[1] ^ st[0], u ^ st[0]};
  endfunction

  function automatic logic [1:0] bit_dist(input logic [1:0] a, input logic [1:0] b);
    logic [1:0] d;
    d = a ^ b;
    return {d[1] & d[0], d[1] ^ d[0]};
  endfunction
endpackage

// File: rtl/avd_encoder.sv
module avd_encoder import avd_pkg::*; (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_en,
  input  logic       in_bit,
  output logic [1:0] sym_out
);
  logic [1:0] sr_q;

  assign sym_out = branch_label(sr_q, in_bit);

  always_ff @(posedge clk) begin
    if (rst)        sr_q <= 2'b00;
    else if (in_en) sr_q <= {in_bit, sr_q[1]};
  end
endmodule

// File: rtl/avd_acs.sv
module avd_acs import avd_pkg::*; #(
  parameter int MW   = 8,
  parameter int HL   = 16,
  parameter int SIDX = 0
)(
  input  logic [1:0]    rx_sym,
  input  logic [MW-1:0] pm_lo,
  input  logic [MW-1:0] pm_hi,
  input  logic          ok_lo,
  input  logic          ok_hi,
  input  logic [HL-1:0] hist_lo,
  input  logic [HL-1:0] hist_hi,
  output logic [MW-1:0] cand,
  output logic          cand_ok,
  output logic [HL-1:0] cand_hist
);
  localparam logic [1:0] PRED_LO = 2'((SIDX % 2) * 2);
  localparam logic [1:0] PRED_HI = 2'((SIDX % 2) * 2 + 1);
  localparam logic       UBIT    = 1'(SIDX / 2);

  logic [1:0]    bm_lo, bm_hi;
  logic [MW:0]   raw_lo, raw_hi;
  logic [MW-1:0] sum_lo, sum_hi;
  logic          take_lo;
  logic [HL-1:0] hist_sel;

  assign bm_lo  = bit_dist(rx_sym, branch_label(PRED_LO, UBIT));
  assign bm_hi  = bit_dist(rx_sym, branch_label(PRED_HI, UBIT));
  assign raw_lo = {1'b0, pm_lo} + (MW+1)'(bm_lo);
  assign raw_hi = {1'b0, pm_hi} + (MW+1)'(bm_hi);
  assign sum_lo = raw_lo[MW] ? {MW{1'b1}} : raw_lo[MW-1:0];
  assign sum_hi = raw_hi[MW] ? {MW{1'b1}} : raw_hi[MW-1:0];

  assign take_lo   = ok_lo && (!ok_hi || (sum_lo <= sum_hi));
  assign cand      = take_lo ? sum_lo : sum_hi;
  assign cand_ok   = ok_lo | ok_hi;
  assign hist_sel  = take_lo ? hist_lo : hist_hi;
  assign cand_hist = {hist_sel[HL-2:0], UBIT};
endmodule

// File: rtl/avd_prune.sv
module avd_prune #(
  parameter int MW   = 8,
  parameter int TW   = 4,
  parameter int NMAX = 4,
  parameter int NS   = 4
)(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  step,
  input  logic [TW-1:0]         thr_cfg,
  input  logic [MW-1:0]         dm,
  input  logic [NS-1:0][MW-1:0] cand,
  input  logic [NS-1:0]         cand_ok,
  output logic [NS-1:0]         keep,
  output logic [NS-1:0][MW-1:0] norm,
  output logic [$clog2(NS)-1:0] best
);
  localparam int NLV = (1 << TW) / 2 + 1;
  localparam int LW  = MW + TW;
  localparam int CW  = 8;
  localparam int SW  = $clog2(NS);
  localparam logic [CW-1:0] NMAX_V = CW'(NMAX);

  logic [NLV-1:0][NS-1:0] pass_lv;
  logic [NLV-1:0][CW-1:0] cnt_lv;
  logic [NS-1:0]          chosen;
  logic                   found;
  logic                   have;
  logic [MW-1:0]          best_m;

  for (genvar k = 0; k < NLV; k++) begin : g_lv
    logic [TW:0] thr_k;
    assign thr_k = ({1'b0, thr_cfg} > (TW+1)'(2 * k)) ? ({1'b0, thr_cfg} - (TW+1)'(2 * k)) : '0;
    for (genvar s = 0; s < NS; s++) begin : g_st
      assign pass_lv[k][s] = cand_ok[s] && (LW'(cand[s]) < (LW'(dm) + LW'(thr_k)));
    end
    assign cnt_lv[k] = CW'($countones(pass_lv[k]));
  end

  always_comb begin
    chosen = '0;
    found  = 1'b0;
    for (int k = 0; k < NLV; k++) begin
      if (!found && (cnt_lv[k] < NMAX_V)) begin
        chosen = pass_lv[k];
        found  = 1'b1;
      end
    end
  end

  always_comb begin
    have   = 1'b0;
    best   = '0;
    best_m = '0;
    for (int s = 0; s < NS; s++) begin
      if (cand_ok[s] && (!have || (cand[s] < best_m))) begin
        have   = 1'b1;
        best   = SW'(s);
        best_m = cand[s];
      end
    end
  end

  assign keep = (chosen != '0) ? chosen : (have ? (NS'(1) << best) : '0);

  for (genvar s = 0; s < NS; s++) begin : g_norm
    assign norm[s] = cand[s] - dm;

    // R6: a state kept alongside others passed the configured threshold
    a_r6_threshold: assert property (@(posedge clk) disable iff (rst)
      step && keep[s] && ($countones(keep) > 1) |-> (LW'(cand[s]) < (LW'(dm) + LW'(thr_cfg))));
  end

  a_r7_cap: assert property (@(posedge clk) disable iff (rst)
    step |-> (($countones(keep) < NMAX) || ($countones(keep) == 1)));

  a_r8_nonempty: assert property (@(posedge clk) disable iff (rst)
    step && (cand_ok != '0) |-> (keep != '0) && ((keep & ~cand_ok) == '0));
endmodule

// File: rtl/avit_decoder.sv
module avit_decoder import avd_pkg::*; #(
  parameter int MW   = 8,
  parameter int HL   = 16,
  parameter int TW   = 4,
  parameter int NMAX = 4
)(
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] thr_cfg,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_sym,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          out_bit
);
  localparam int SW = $clog2(NS);
  localparam int FW = $clog2(HL);
  localparam logic [FW-1:0] FILL_LAST = FW'(HL - 1);

  logic [NS-1:0][MW-1:0] pm_q, cand, norm;
  logic [NS-1:0]         ok_q, cand_ok, keep;
  logic [NS-1:0][HL-1:0] hist_q, cand_hist;
  logic [FW-1:0]         fill_q;
  logic [SW-1:0]         best;
  logic [MW-1:0]         dm;
  logic                  step;
  logic                  ov_q, ob_q;

  assign in_ready  = !ov_q || out_ready;
  assign step      = in_valid && in_ready;
  assign out_valid = ov_q;
  assign out_bit   = ob_q;

  always_comb begin
    dm = {MW{1'b1}};
    for (int s = 0; s < NS; s++) begin
      if (ok_q[s] && (pm_q[s] < dm)) dm = pm_q[s];
    end
  end

  for (genvar g = 0; g < NS; g++) begin : g_acs
    localparam int PLO = (g % 2) * 2;
    localparam int PHI = PLO + 1;
    avd_acs #(.MW(MW), .HL(HL), .SIDX(g)) u_acs (
      .rx_sym    (in_sym),
      .pm_lo     (pm_q[PLO]),
      .pm_hi     (pm_q[PHI]),
      .ok_lo     (ok_q[PLO]),
      .ok_hi     (ok_q[PHI]),
      .hist_lo   (hist_q[PLO]),
      .hist_hi   (hist_q[PHI]),
      .cand      (cand[g]),
      .cand_ok   (cand_ok[g]),
      .cand_hist (cand_hist[g])
    );
  end

  avd_prune #(.MW(MW), .TW(TW), .NMAX(NMAX), .NS(NS)) u_prune (
    .clk     (clk),
    .rst     (rst),
    .step    (step),
    .thr_cfg (thr_cfg),
    .dm      (dm),
    .cand    (cand),
    .cand_ok (cand_ok),
    .keep    (keep),
    .norm    (norm),
    .best    (best)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pm_q   <= '0;
      ok_q   <= NS'(1);
      hist_q <= '0;
      fill_q <= '0;
      ov_q   <= 1'b0;
      ob_q   <= 1'b0;
    end else begin
      if (step) begin
        for (int s = 0; s < NS; s++) pm_q[s] <= keep[s] ? norm[s] : '0;
        ok_q   <= keep;
        hist_q <= cand_hist;
        if (fill_q != FILL_LAST) fill_q <= fill_q + 1'b1;
      end
      if (step && (fill_q == FILL_LAST)) begin
        ov_q <= 1'b1;
        ob_q <= cand_hist[best][HL-1];
      end else if (out_ready) begin
        ov_q <= 1'b0;
      end
    end
  end

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    ov_q && !out_ready |=> ov_q && $stable(ob_q));

  a_r10_frozen: assert property (@(posedge clk) disable iff (rst)
    ov_q && !out_ready |=> $stable(pm_q) && $stable(ok_q) && $stable(hist_q));

  a_r8_alive: assert property (@(posedge clk) disable iff (rst) ok_q != '0);

  a_r4_after_step: assert property (@(posedge clk) disable iff (rst)
    $rose(ov_q) |-> $past(step));

  for (genvar s = 0; s < NS; s++) begin : g_chk
    // R9: stored costs stay clear of saturation
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
      ok_q[s] |-> (pm_q[s] != {MW{1'b1}}));
  end
endmodule

// File: tb/sim_avit_decoder.sv
module sim_avit_decoder;
  timeunit 1ns;
  timeprecision 1ps;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] thr_cfg = 4'd6;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [1:0] in_sym = 2'b00;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic       out_bit;
  logic       enc_en = 1'b0;
  logic       enc_bit = 1'b0;
  logic [1:0] enc_sym;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  avit_decoder u0 (
    .clk(clk), .rst(rst), .thr_cfg(thr_cfg),
    .in_valid(in_valid), .in_ready(in_ready), .in_sym(in_sym),
    .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit)
  );

  avd_encoder u_enc (
    .clk(clk), .rst(rst), .in_en(enc_en), .in_bit(enc_bit), .sym_out(enc_sym)
  );

  // seed, threshold, error spacing (0 = clean), requirement number
  localparam logic [35:0] VEC [6] = '{
    {16'hACE1, 4'd6,  8'd0,  8'd3},
    {16'h1D2B, 4'd6,  8'd24, 8'd5},
    {16'hB400, 4'd1,  8'd0,  8'd6},
    {16'h7E55, 4'd15, 8'd0,  8'd7},
    {16'h5A5A, 4'd0,  8'd0,  8'd8},
    {16'hC3F1, 4'd8,  8'd30, 8'd5}
  };

  function automatic string tag_of(input int n);
    case (n)
      3: return "R3";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [1:0] enc_pair(input logic [1:0] st, input logic u);
    return {u ^ st[1] ^ st[0], u ^ st[0]};
  endfunction

  function automatic logic [15:0] lfsr_next(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic [3:0] thr);
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1; thr_cfg = thr;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic feed(input logic [1:0] s);
    @(negedge clk);
    in_valid = 1'b1;
    in_sym = s;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic run_vec(input logic [15:0] seed, input logic [3:0] thr, input int nbits,
                         input int sp, input string tag);
    logic [15:0] lf;
    logic [1:0]  st;
    logic [31:0] sh;
    logic [1:0]  s;
    logic        u;
    int mism;
    int nout;
    lf = seed; st = 2'b00; sh = '0; mism = 0; nout = 0;
    do_reset(thr);
    for (int i = 0; i < nbits + 15; i++) begin
      if (i < nbits) begin
        lf = lfsr_next(lf);
        u = lf[0];
      end else begin
        u = 1'b0;
      end
      s = enc_pair(st, u);
      st = {u, st[1]};
      if (sp > 0 && i < nbits && (i % sp) == sp / 2) s = s ^ ((((i / sp) % 2) == 1) ? 2'b01 : 2'b10);
      sh = {sh[30:0], u};
      feed(s);
      if (out_valid) begin
        nout++;
        if (out_bit !== sh[15]) mism++;
      end
    end
    chk(mism == 0, tag, "decoded bit mismatches", mism, 0);
    chk(nout == nbits, tag, "decoded bit count", nout, nbits);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run not finished actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    logic [1:0]  st;
    logic [31:0] sh;
    logic        u;
    int          mism;

    // R2: reset state at the ports
    do_reset(4'd6);
    #1;
    chk(out_valid == 1'b0, "R2", "out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R2", "in_ready after reset", int'(in_ready), 1);

    // R1: encoder module against its equations
    st = 2'b00; lf = 16'h3C5A; mism = 0;
    for (int i = 0; i < 24; i++) begin
      lf = lfsr_next(lf);
      u = lf[0];
      @(negedge clk);
      enc_en = 1'b1; enc_bit = u;
      #1;
      if (enc_sym !== enc_pair(st, u)) mism++;
      @(posedge clk);
      st = {u, st[1]};
    end
    @(negedge clk);
    enc_en = 1'b0;
    chk(mism == 0, "R1", "encoder pair mismatches", mism, 0);

    // table of stream runs
    for (int v = 0; v < 6; v++) begin
      run_vec(VEC[v][35:20], VEC[v][19:16], 48, int'(VEC[v][15:8]), tag_of(int'(VEC[v][7:0])));
    end

    // R4 latency and R10 back-pressure
    do_reset(4'd6);
    st = 2'b00; sh = '0; lf = 16'h1234;
    for (int i = 0; i < 15; i++) begin
      lf = lfsr_next(lf);
      u = lf[0];
      sh = {sh[30:0], u};
      feed(enc_pair(st, u));
      st = {u, st[1]};
    end
    chk(out_valid == 1'b0, "R4", "out_valid after 15 pairs", int'(out_valid), 0);
    lf = lfsr_next(lf);
    u = lf[0];
    sh = {sh[30:0], u};
    feed(enc_pair(st, u));
    st = {u, st[1]};
    chk(out_valid == 1'b1, "R4", "out_valid after 16 pairs", int'(out_valid), 1);
    chk(out_bit == sh[15], "R4", "first decoded bit", int'(out_bit), int'(sh[15]));

    lf = lfsr_next(lf);
    u = lf[0];
    sh = {sh[30:0], u};
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1;
    in_sym = enc_pair(st, u);
    st = {u, st[1]};
    repeat (3) @(posedge clk);
    #1;
    chk(in_ready == 1'b0, "R10", "in_ready while stalled", int'(in_ready), 0);
    chk(out_valid == 1'b1, "R10", "out_valid held", int'(out_valid), 1);
    chk(out_bit == sh[16], "R10", "out_bit held", int'(out_bit), int'(sh[16]));
    @(negedge clk);
    out_ready = 1'b1;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    chk(out_valid == 1'b1, "R10", "out_valid after release", int'(out_valid), 1);
    chk(out_bit == sh[15], "R10", "bit from held pair", int'(out_bit), int'(sh[15]));

    // R9: long erroneous run, accumulated error count beyond the metric range
    run_vec(16'h9C37, 4'd8, 7000, 22, "R9");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule